// File: doc/BRIEF.md
# Scoreboard Dynamic Issue Controller

This controller sits between an in-order instruction front end and a set of multi-cycle functional units. It tracks hazards so that instructions leave the front end in program order but fetch their operands, execute and retire results out of order. Each unit has a status record holding its busy flag, its destination register, its two source registers, the units that will produce those sources and two ready flags. A table indexed by register names the unit that will next write that register.

Decoded instructions arrive on a valid/ready stream. The producer holds `in_valid` and all instruction fields steady until it sees `in_valid && in_ready` at a rising edge. `in_ready` is a combinational function of the offered fields and the scoreboard state. While `in_ready` is low nothing behind the held instruction can be offered, so issue stays strictly in order. The controller produces one operand-read enable and one write-back enable per unit, plus the register being written back. The block models each unit's latency with its own counter, so it needs no completion inputs. There is no forwarding: a consumer reads a new value only after the producer's write-back cycle.

Top module: `scoreboard_issue_ctl`

## Requirements
- R1: After a synchronous reset no unit is busy: `in_ready` is high for any offered instruction, and `rd_en` and `wb_en` are all zero.
- R2: Class encoding is 0 = integer (unit 1), 1 = multiply (unit 2, or unit 3 when 2 is busy), 2 = add (unit 4) and 3 = divide (unit 5). An instruction is accepted only when a unit of its class is free and no pending writer of its destination exists, except a writer whose write-back occurs in that same cycle. `issue_unit` reports the unit taken (bits 0..4 of `rd_en`/`wb_en` map to units 1..5).
- R3: While `in_ready` is low, the held instruction waits and nothing issues; the number of stall cycles equals the hazard duration.
- R4: A unit whose two sources are ready raises its `rd_en` bit for exactly one cycle, in the cycle after issue when no producer is pending.
- R5: A consumer of a pending register raises `rd_en` in the cycle after the producer's write-back cycle (no forwarding).
- R6: With no write-back contention, `wb_en` rises exactly latency+1 cycles after the read cycle. The latencies are integer 1, multiply 10, add 2 and divide 40.
- R7: A finished unit does not write back while another unit still has to read the old value of its destination register; it writes in the cycle after that reader's `rd_en`.
- R8: At most one `wb_en` bit is high per cycle. Ties go to the lowest unit number, and `wb_dst` carries the destination of the granted unit.
- R9: An instruction offered in the cycle its destination's or source's writer is written back is accepted in that cycle, and it treats that source as ready.
- R10: A busy unit becomes free in the cycle after its write-back, and an instruction stalled on it issues then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted at this edge if valid |
| in_cls | input | 2 | Unit class of the offered instruction |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| issue_unit | output | 3 | Unit chosen for the offered instruction, 0 if none |
| rd_en | output | 5 | Per-unit operand-read enable |
| wb_en | output | 5 | Per-unit write-back enable |
| wb_dst | output | 5 | Register written back this cycle |

## Verification
On every cycle the assertions check that at most one write-back is granted and that each read enable lasts a single cycle. They also check that no write-back overtakes a pending reader of the old value, that a write-back never follows its read cycle directly, and that a busy unit is never loaded. Cycle placement can only be shown by the bench's scenarios. These cover the exact latency per class, RAW wake-up one cycle after the producer's write-back, stall lengths for busy units and pending destinations, same-cycle issue against a write-back, tie priority and the reported destination for every register.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NU     = 5;
  localparam int NREG   = 32;
  localparam int REG_AW = $clog2(NREG);
  localparam int UID_W  = $clog2(NU + 1);

  typedef enum logic [1:0] {CLS_INT = 2'd0, CLS_MUL = 2'd1, CLS_ADD = 2'd2, CLS_DIV = 2'd3} cls_e;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_EXEC, PH_DONE} phase_e;
endpackage

// File: rtl/sb_unit_rec.sv
module sb_unit_rec
  import sb_pkg::*;
#(
  parameter int LAT   = 2,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_ld,
  input  logic [REG_AW-1:0] iss_fi,
  input  logic [REG_AW-1:0] iss_fj,
  input  logic [REG_AW-1:0] iss_fk,
  input  logic [UID_W-1:0]  iss_qj,
  input  logic [UID_W-1:0]  iss_qk,
  input  logic [UID_W-1:0]  wb_uid,
  input  logic              wb_grant,
  output logic              busy,
  output logic [REG_AW-1:0] fi,
  output logic [REG_AW-1:0] fj,
  output logic [REG_AW-1:0] fk,
  output logic              rj,
  output logic              rk,
  output logic              rd_en,
  output logic              done_req
);
  phase_e             phase;
  logic [UID_W-1:0]   qj, qk;
  logic [CNT_W-1:0]   cnt;

  assign rd_en    = (phase == PH_WAIT) && rj && rk;
  assign done_req = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; phase <= PH_IDLE;
      rj <= 1'b0; rk <= 1'b0; qj <= '0; qk <= '0; cnt <= '0;
      fi <= '0; fj <= '0; fk <= '0;
    end else if (issue_ld) begin
      busy <= 1'b1; phase <= PH_WAIT;
      fi <= iss_fi; fj <= iss_fj; fk <= iss_fk;
      qj <= iss_qj; qk <= iss_qk;
      rj <= (iss_qj == '0); rk <= (iss_qk == '0);
    end else begin
      case (phase)
        PH_WAIT: begin
          if (rd_en) begin
            rj <= 1'b0; rk <= 1'b0;
            cnt <= CNT_W'(LAT);
            phase <= PH_EXEC;
          end else begin
            if (wb_uid != '0 && qj == wb_uid) begin rj <= 1'b1; qj <= '0; end
            if (wb_uid != '0 && qk == wb_uid) begin rk <= 1'b1; qk <= '0; end
          end
        end
        PH_EXEC: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) phase <= PH_DONE;
        end
        PH_DONE: if (wb_grant) begin busy <= 1'b0; phase <= PH_IDLE; end
        default: ;
      endcase
    end
  end

  assert_read_once_R4: assert property (@(posedge clk) disable iff (rst) rd_en |=> !rd_en);
  assert_no_load_busy_R10: assert property (@(posedge clk) disable iff (rst) issue_ld |-> !busy);
  assert_exec_gap_R6: assert property (@(posedge clk) disable iff (rst) wb_grant |-> !$past(rd_en));
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int N  = 5,
  parameter int UW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [UW-1:0] grant_uid
);
  always_comb begin
    grant     = '0;
    grant_uid = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && grant_uid == '0) begin
        grant[i]  = 1'b1;
        grant_uid = UW'(i + 1);
      end
    end
  end

  assert_wb_onehot_R8: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
endmodule

// File: rtl/scoreboard_issue_ctl.sv
module scoreboard_issue_ctl
  import sb_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_cls,
  input  logic [REG_AW-1:0] in_dst,
  input  logic [REG_AW-1:0] in_src1,
  input  logic [REG_AW-1:0] in_src2,
  output logic [UID_W-1:0]  issue_unit,
  output logic [NU-1:0]     rd_en,
  output logic [NU-1:0]     wb_en,
  output logic [REG_AW-1:0] wb_dst
);
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [NU-1:0]      busy, rj, rk, done_req, war_ok, issue_ld;
  logic [REG_AW-1:0]  fi_a [NU];
  logic [REG_AW-1:0]  fj_a [NU];
  logic [REG_AW-1:0]  fk_a [NU];
  logic [UID_W-1:0]   res_tab [NREG];
  logic [UID_W-1:0]   wb_uid, tgt, qj_in, qk_in;
  logic               waw, fire;

  // pick the target unit for the offered class
  always_comb begin
    tgt = '0;
    case (cls_e'(in_cls))
      CLS_INT: if (!busy[0]) tgt = UID_W'(1);
      CLS_MUL: if (!busy[1]) tgt = UID_W'(2); else if (!busy[2]) tgt = UID_W'(3);
      CLS_ADD: if (!busy[3]) tgt = UID_W'(4);
      CLS_DIV: if (!busy[4]) tgt = UID_W'(5);
      default: tgt = '0;
    endcase
  end

  // a writer finishing this cycle no longer counts as pending
  assign waw        = (res_tab[in_dst] != '0) && (res_tab[in_dst] != wb_uid);
  assign in_ready   = (tgt != '0) && !waw;
  assign fire       = in_valid && in_ready;
  assign issue_unit = tgt;
  assign qj_in      = (res_tab[in_src1] == wb_uid) ? '0 : res_tab[in_src1];
  assign qk_in      = (res_tab[in_src2] == wb_uid) ? '0 : res_tab[in_src2];

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int LAT_U = (u == 0) ? LAT_INT : (u <= 2) ? LAT_MUL : (u == 3) ? LAT_ADD : LAT_DIV;
    assign issue_ld[u] = fire && (tgt == UID_W'(u + 1));
    sb_unit_rec #(.LAT(LAT_U), .CNT_W(CNT_W)) rec_i (
      .clk(clk), .rst(rst), .issue_ld(issue_ld[u]),
      .iss_fi(in_dst), .iss_fj(in_src1), .iss_fk(in_src2),
      .iss_qj(qj_in), .iss_qk(qk_in),
      .wb_uid(wb_uid), .wb_grant(wb_en[u]),
      .busy(busy[u]), .fi(fi_a[u]), .fj(fj_a[u]), .fk(fk_a[u]),
      .rj(rj[u]), .rk(rk[u]), .rd_en(rd_en[u]), .done_req(done_req[u])
    );
  end

  // WAR: hold write-back while another unit still needs the old value
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      war_ok[u] = 1'b1;
      for (int f = 0; f < NU; f++) begin
        if (f != u && busy[f] &&
            ((rj[f] && fj_a[f] == fi_a[u]) || (rk[f] && fk_a[f] == fi_a[u])))
          war_ok[u] = 1'b0;
      end
    end
  end

  sb_wb_arbiter #(.N(NU), .UW(UID_W)) arb_i (
    .clk(clk), .rst(rst), .req(done_req & war_ok), .grant(wb_en), .grant_uid(wb_uid)
  );

  always_comb begin
    wb_dst = '0;
    for (int u = 0; u < NU; u++) if (wb_en[u]) wb_dst = fi_a[u];
  end

  // register result table: write-back clears, a same-cycle issue overrides
  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (rst) res_tab[r] <= '0;
      else if (fire && in_dst == REG_AW'(r)) res_tab[r] <= tgt;
      else if (wb_uid != '0 && wb_dst == REG_AW'(r)) res_tab[r] <= '0;
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_chk_u
    for (genvar f = 0; f < NU; f++) begin : g_chk_f
      if (u != f) begin : g_pair
        assert_war_hold_R7: assert property (@(posedge clk) disable iff (rst)
          !(wb_en[u] && busy[f] && rj[f] && fj_a[f] == fi_a[u]));
      end
    end
  end
endmodule

// File: tb/scoreboard_issue_ctl_tb_top.sv
module scoreboard_issue_ctl_tb_top;
  localparam int L_INT = 1, L_MUL = 10, L_ADD = 2, L_DIV = 40;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_ready;
  logic [1:0] in_cls = '0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0, wb_dst;
  logic [2:0] issue_unit;
  logic [4:0] rd_en, wb_en;
  int cyc = 0, checks = 0, errors = 0;
  int rd_cyc[6], wb_cyc[6], wb_reg[6], rd_cnt[6];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scoreboard_issue_ctl dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .issue_unit(issue_unit),
    .rd_en(rd_en), .wb_en(wb_en), .wb_dst(wb_dst)
  );

  always @(negedge clk) begin
    #1;
    for (int u = 1; u <= 5; u++) begin
      if (rd_en[u-1]) begin rd_cyc[u] = cyc; rd_cnt[u]++; end
      if (wb_en[u-1]) begin wb_cyc[u] = cyc; wb_reg[u] = int'(wb_dst); end
    end
  end

  task automatic clear_log();
    for (int u = 0; u < 6; u++) begin rd_cyc[u] = -1; wb_cyc[u] = -1; wb_reg[u] = -1; rd_cnt[u] = 0; end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [4:0] d, input logic [4:0] s1,
                      input logic [4:0] s2, output int ic, output int iu, output int stall);
    @(negedge clk);
    in_cls = c; in_dst = d; in_src1 = s1; in_src2 = s2; in_valid = 1'b1; stall = 0;
    #1;
    while (!in_ready) begin stall++; @(negedge clk); #1; end
    ic = cyc; iu = int'(issue_unit);
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, au, ast, b, bu, bst, c, cu, cst;
    int lat[4];
    lat[0] = L_INT; lat[1] = L_MUL; lat[2] = L_ADD; lat[3] = L_DIV;
    clear_log();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 ready", int'(in_ready), 1);
    check("R1 rd_en", int'(rd_en), 0);
    check("R1 wb_en", int'(wb_en), 0);

    // R4 R6 per-class latency sweep
    for (int k = 0; k < 4; k++) begin
      clear_log();
      send(2'(k), 5'(k + 1), 5'd9, 5'd10, a, au, ast);
      idle(lat[k] + 6);
      check("R2 unit", au, (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 4 : 5);
      check("R4 read cycle", rd_cyc[au], a + 1);
      check("R4 single read", rd_cnt[au], 1);
      check("R6 latency", wb_cyc[au] - rd_cyc[au], lat[k] + 1);
    end

    // R8 destination reported for every register
    for (int d = 0; d < 32; d++) begin
      clear_log();
      send(2'd0, 5'(d), 5'(31 - d), 5'(d ^ 5), a, au, ast);
      idle(L_INT + 4);
      check("R8 wb_dst", wb_reg[1], d);
    end

    // R5 R7 RAW wake-up and WAR hold
    clear_log();
    send(2'd1, 5'd10, 5'd11, 5'd12, a, au, ast);
    send(2'd2, 5'd13, 5'd10, 5'd14, b, bu, bst);
    send(2'd0, 5'd14, 5'd15, 5'd16, c, cu, cst);
    idle(L_MUL + L_ADD + 10);
    check("R5 consumer read", rd_cyc[4], wb_cyc[2] + 1);
    check("R7 war hold", wb_cyc[1], rd_cyc[4] + 1);
    check("R7 war wb reg", wb_reg[1], 14);

    // R8 tie priority
    clear_log();
    send(2'd2, 5'd20, 5'd21, 5'd22, a, au, ast);
    send(2'd0, 5'd23, 5'd24, 5'd25, b, bu, bst);
    idle(8);
    check("R8 low id first", wb_cyc[1], a + L_ADD + 2);
    check("R8 loser next", wb_cyc[4], a + L_ADD + 3);

    // R9 R3 WAW stall then same-cycle issue with bypassed source
    clear_log();
    send(2'd2, 5'd7, 5'd1, 5'd2, a, au, ast);
    send(2'd1, 5'd7, 5'd7, 5'd3, b, bu, bst);
    idle(L_MUL + 6);
    check("R9 issue at wb", b, wb_cyc[4]);
    check("R3 waw stall", bst, L_ADD + 1);
    check("R9 src ready", rd_cyc[bu], b + 1);

    // R10 R3 busy divider
    clear_log();
    send(2'd3, 5'd1, 5'd2, 5'd3, a, au, ast);
    send(2'd3, 5'd2, 5'd4, 5'd5, b, bu, bst);
    check("R10 free after wb", b, a + L_DIV + 3);
    check("R3 busy stall", bst, L_DIV + 2);
    idle(L_DIV + 6);

    // R2 R10 multiplier pair and third multiply
    clear_log();
    send(2'd1, 5'd3, 5'd0, 5'd0, a, au, ast);
    send(2'd1, 5'd4, 5'd0, 5'd0, b, bu, bst);
    send(2'd1, 5'd5, 5'd0, 5'd0, c, cu, cst);
    check("R2 first mul", au, 2);
    check("R2 second mul", bu, 3);
    check("R10 third mul unit", cu, 2);
    check("R10 third mul cycle", c, a + L_MUL + 3);
    idle(L_MUL + 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule